// File: doc/BRIEF.md
# Divided Clock Output Generator

This block derives an auxiliary clock from the system clock and drives it onto a single output pin. A small configuration register selects one of three behaviours: the output is switched off and held low, the output carries the system clock unchanged, or the output carries the system clock divided by an even ratio between 2 and 14 with a 50% duty cycle. The ratio comes from a 3-bit code. Codes 0 through 6 give a ratio of twice the code plus two. The all-ones code does not select the largest ratio. It selects pass-through instead.

Software writes the register through a one-cycle write strobe. The written value is stored at once and can be read back. It becomes the active setting only when the output period that is running completes, so a change never shortens a high or low phase. A further register bit selects an alternative register-layout mode. The block stores that bit and presents it on an output, and it has no effect on the clock.

Top module: `clkdiv_out`

## Requirements
- R1: While reset is asserted and directly after it, `cfg_rdata` reads 0, the active code is 0, the active off flag is 0, and `clk_out` is low.
- R2: With active code c in 0..6 and off clear, `clk_out` has a period of 2*(c+1) system cycles. It is high for the first c+1 cycles after a period start and low for the remaining c+1 cycles.
- R3: With active code 7 and off clear, `clk_out` is high while `clk` is high and low while `clk` is low, once a full cycle has passed after pass-through became active.
- R4: With the active off flag set, `clk_out` stays low.
- R5: A cycle with `cfg_we` high stores `cfg_wdata` bits [2:0] as the code, bit 3 as the off flag and bit 4 as the layout-mode bit. From the next cycle, `cfg_rdata` returns these bits in the same positions, with bits [7:5] reading 0. `layout_ext` follows the stored bit 4. The layout bit has no effect on `clk_out`.
- R6: A stored setting becomes active (`active_code`, `active_off`) only at a period boundary. For the divider, that is the edge that ends the low phase. Off and pass-through have a boundary at every edge. The new setting starts with a fresh period, high first when dividing.
- R7: When the setting changes, no high or low phase of `clk_out` is cut short or stretched beyond what the settings before and after the change define.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write strobe for the configuration register |
| cfg_wdata | input | 8 | Write data: [2:0] code, [3] off, [4] layout mode |
| cfg_rdata | output | 8 | Stored register value |
| layout_ext | output | 1 | Stored layout-mode bit |
| active_code | output | 3 | Code currently driving the output |
| active_off | output | 1 | Off flag currently driving the output |
| clk_out | output | 1 | Generated clock |

## Verification
The bench goes after writes that land in the middle of a period. A design that applied them at once would show active settings changing mid-period, and its output would have a short high or low phase. Code 7 is checked as pass-through. An implementation that treated it as a ratio of 16 would hold the output high through a clock-low sample. Switching between pass-through, off and the divided modes in both directions checks that the output mux changes cleanly. A missing half-cycle delay on the pass-through enable would break the high/low samples taken around these switches. Writes with bits 7:5 set and with the layout bit set show any bleed of unused bits into the readback or into the clock.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int CODE_W     = 3;
  localparam int CNT_W      = CODE_W + 1;
  localparam int REG_W      = 8;
  localparam int CODE_LSB   = 0;
  localparam int OFF_BIT    = CODE_LSB + CODE_W;
  localparam int LAYOUT_BIT = OFF_BIT + 1;
  localparam logic [CODE_W-1:0] BYPASS_CODE = '1;

  typedef struct packed {
    logic              layout;
    logic              off;
    logic [CODE_W-1:0] code;
  } clkdiv_cfg_t;

  // Cycles spent in each half of a divided period.
  function automatic logic [CNT_W-1:0] half_len(input logic [CODE_W-1:0] code);
    return CNT_W'(code) + CNT_W'(1);
  endfunction

  function automatic logic is_divided(input clkdiv_cfg_t c);
    return !c.off && (c.code != BYPASS_CODE);
  endfunction

  function automatic logic is_bypass(input clkdiv_cfg_t c);
    return !c.off && (c.code == BYPASS_CODE);
  endfunction

  function automatic clkdiv_cfg_t unpack_reg(input logic [REG_W-1:0] d);
    clkdiv_cfg_t c;
    c.code   = d[CODE_LSB +: CODE_W];
    c.off    = d[OFF_BIT];
    c.layout = d[LAYOUT_BIT];
    return c;
  endfunction

  function automatic logic [REG_W-1:0] pack_reg(input clkdiv_cfg_t c);
    logic [REG_W-1:0] d;
    d = '0;
    d[CODE_LSB +: CODE_W] = c.code;
    d[OFF_BIT]            = c.off;
    d[LAYOUT_BIT]         = c.layout;
    return d;
  endfunction
endpackage

// File: rtl/clkdiv_cfg_reg.sv
module clkdiv_cfg_reg
  import clkdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output clkdiv_cfg_t      cfg_q,
  output logic [REG_W-1:0] rdata
);
  logic unused_hi_bits;
  assign unused_hi_bits = ^wdata[REG_W-1:LAYOUT_BIT+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cfg_q <= '0;
    else if (we) cfg_q <= unpack_reg(wdata);
  end

  assign rdata = pack_reg(cfg_q);

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (rdata[LAYOUT_BIT:0] == $past(wdata[LAYOUT_BIT:0]))); // R5
endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter
  import clkdiv_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] half,
  input  logic         load,
  input  logic         load_high,
  output logic         phase_q,
  output logic         half_done
);
  logic [W-1:0] cnt_q;

  assign half_done = (cnt_q == half - W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (load) begin
      cnt_q   <= '0;
      phase_q <= load_high;
    end else if (half_done) begin
      cnt_q   <= '0;
      phase_q <= ~phase_q;
    end else begin
      cnt_q   <= cnt_q + W'(1);
    end
  end

  AST_CNT_BELOW_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < half); // R2
  AST_PHASE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !half_done) |=> $stable(phase_q)); // R7
endmodule

// File: rtl/clkdiv_sequencer.sv
module clkdiv_sequencer
  import clkdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  clkdiv_cfg_t      pend,
  input  logic             phase,
  input  logic             half_done,
  output clkdiv_cfg_t      act_q,
  output logic             boundary,
  output logic             load_high,
  output logic             bypass_on,
  output logic [CNT_W-1:0] half
);
  logic divided;

  assign divided   = is_divided(act_q);
  assign boundary  = !divided || (!phase && half_done);
  assign load_high = is_divided(pend);
  assign bypass_on = is_bypass(act_q);
  assign half      = half_len(act_q.code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        act_q <= '0;
    else if (boundary) act_q <= pend;
  end

  AST_HOLD_MID_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> (act_q == $past(act_q))); // R6
endmodule

// File: rtl/clkdiv_out.sv
module clkdiv_out
  import clkdiv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  output logic              layout_ext,
  output logic [CODE_W-1:0] active_code,
  output logic              active_off,
  output logic              clk_out
);
  clkdiv_cfg_t      pend;
  clkdiv_cfg_t      act;
  logic             phase;
  logic             half_done;
  logic             boundary;
  logic             load_high;
  logic             bypass_on;
  logic [CNT_W-1:0] half;
  logic             gate_q;
  logic             unused_act_layout;

  clkdiv_cfg_reg u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .cfg_q (pend),
    .rdata (cfg_rdata)
  );

  clkdiv_sequencer u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .pend      (pend),
    .phase     (phase),
    .half_done (half_done),
    .act_q     (act),
    .boundary  (boundary),
    .load_high (load_high),
    .bypass_on (bypass_on),
    .half      (half)
  );

  clkdiv_counter #(.W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .half      (half),
    .load      (boundary),
    .load_high (load_high),
    .phase_q   (phase),
    .half_done (half_done)
  );

  // Pass-through enable changes only while clk is low.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= bypass_on;
  end

  assign clk_out           = (clk & gate_q) | phase;
  assign layout_ext        = pend.layout;
  assign active_code       = act.code;
  assign active_off        = act.off;
  assign unused_act_layout = act.layout;

  AST_OFF_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    act.off |-> !phase); // R4
  AST_BYPASS_NO_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    bypass_on |-> !phase); // R3
endmodule

// File: tb/tb_clkdiv_out.sv
module tb_clkdiv_out;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cfg_rdata;
  logic       layout_ext;
  logic [2:0] active_code;
  logic       active_off;
  logic       clk_out;

  int checks = 0;
  int errors = 0;

  // model state
  int   m_pcode = 0, m_acode = 0, m_pos = 1;
  logic m_poff = 0, m_play = 0, m_aoff = 0, m_phase = 0, m_byp = 0, prev_byp = 0;

  always #5 clk = ~clk;

  clkdiv_out dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .layout_ext(layout_ext), .active_code(active_code),
    .active_off(active_off), .clk_out(clk_out)
  );

  function automatic int period_of(input int code);
    return (code == 7) ? 1 : 2 * code + 2;
  endfunction

  function automatic logic divides(input int code, input logic off);
    return !off && code != 7;
  endfunction

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic we, input logic [7:0] d);
    int   n;
    logic hi_exp;
    string tag;
    cfg_we = we;
    cfg_wdata = d;
    @(posedge clk);
    prev_byp = m_byp;
    n = period_of(m_acode);
    if (!divides(m_acode, m_aoff) || m_pos == n - 1) begin
      m_acode = m_pcode;
      m_aoff  = m_poff;
      m_pos   = 0;
    end else begin
      m_pos++;
    end
    if (we) begin
      m_pcode = int'(d[2:0]);
      m_poff  = d[3];
      m_play  = d[4];
    end
    m_phase = divides(m_acode, m_aoff) && (m_pos < period_of(m_acode) / 2);
    m_byp   = !m_aoff && m_acode == 7;
    tag = m_aoff ? "R4" : (m_acode == 7 ? "R3" : "R2");
    hi_exp = m_phase | prev_byp;
    #2;
    check(clk_out === hi_exp, prev_byp ? "R3 clk-high sample" : "R7 clk-high sample",
          int'(clk_out), int'(hi_exp));
    @(negedge clk);
    #1;
    check(clk_out === m_phase, tag, int'(clk_out), int'(m_phase));
    check(active_code === 3'(m_acode) && active_off === m_aoff, "R6 active setting",
          int'({active_off, active_code}), int'({m_aoff, 3'(m_acode)}));
    check(cfg_rdata === {3'b000, m_play, m_poff, 3'(m_pcode)}, "R5 readback",
          int'(cfg_rdata), int'({3'b000, m_play, m_poff, 3'(m_pcode)}));
    check(layout_ext === m_play, "R5 layout bit", int'(layout_ext), int'(m_play));
    cfg_we = 1'b0;
  endtask

  task automatic run(input int cycles);
    for (int i = 0; i < cycles; i++) step(1'b0, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    check(clk_out === 1'b0, "R1 clk_out in reset", int'(clk_out), 0);
    check(cfg_rdata === 8'h00, "R1 register in reset", int'(cfg_rdata), 0);
    check(active_code === 3'd0 && active_off === 1'b0, "R1 active in reset",
          int'({active_off, active_code}), 0);
    rst_n = 1'b1;
    run(8);                      // R1 default: divide by 2
    step(1'b1, 8'h02); run(20);  // R2 divide by 6, mid-period write
    step(1'b1, 8'h06); run(40);  // R2 divide by 14
    step(1'b1, 8'h07); run(10);  // R3 pass-through
    step(1'b1, 8'h08); run(10);  // R4 off
    step(1'b1, 8'h17); run(6);   // R3 from off, layout set
    step(1'b1, 8'hE1); run(3);   // R5 upper bits ignored; R6 mid-period
    step(1'b1, 8'h05); run(2);   // R7 change again before boundary
    step(1'b1, 8'hFF); run(6);   // R4 off with all bits
    step(1'b1, 8'h10); run(12);  // R5 layout does not affect clock
    for (int i = 0; i < 600; i++) begin
      logic       w;
      logic [7:0] d;
      w = ($urandom % 8) == 0;
      d = 8'($urandom);
      step(w, d);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule